// File: doc/BRIEF.md
# Open-drain bus repeater

This block joins two open-drain two-wire bus segments, called side 1 and side 2, at the digital level. Each line (data and clock) is carried by two opposite one-way channels. Each channel forwards a low seen on one side, after a fixed delay, to an active-low pull-down enable on the other side. Each port presents a sampled line level (1 = high, 0 = low) and a pull-down enable (0 = pull the line low, 1 = release it so it floats high).

The repeater must not latch a low it created itself. The block tracks, per line, which side currently owns the low. While one side owns a line, any low on the opposite side is treated as the repeater's own copy and is not sent back. Ownership ends only when the owning side has gone high and the repeater's copy on the far side has fully drained. If both sides go low in the same cycle, side 2 wins. A configuration input turns the clock line into a one-way channel from side 1 to side 2. The data line stays two-way in that mode.

Line index 0 is the data line and line index 1 is the clock line. The channel delay `DELAY` (default 2 cycles) applies to both directions.

Top module: `brep_top`

## Requirements
- R1: Synchronous active-high reset releases every pull-down enable (all ones) in the first cycle after the reset edge. Reset also clears ownership.
- R2: Take an idle line. A low held on its side-1 input makes the side-2 enable go to 0 exactly `DELAY` rising edges later. When the side-1 input returns high, the side-2 enable goes back to 1 exactly `DELAY` edges later.
- R3: Take an idle, two-way line. A low held on its side-2 input makes the side-1 enable go to 0 exactly `DELAY` rising edges later. The enable is released `DELAY` edges after the side-2 input returns high.
- R4: While side 1 owns a line, the side-1 enable of that line stays at 1. The side-2 copy is never reflected back, and the line returns to idle after release.
- R5: While side 2 owns a line, the side-2 enable of that line stays at 1.
- R6: When an idle line sees a low on both inputs in the same cycle, side 2 takes ownership: the side-1 enable goes low and the side-2 enable stays high. Suppose side 2 then releases while side 1 is still low. Once the repeater's drive on side 1 has drained, the side-1 low is forwarded to side 2.
- R7: With `clk_oneway` = 1, a low on the side-2 clock input (index 1) never reaches the side-1 clock enable, and side-1 clock lows still reach side 2. The data line (index 0) behaves as in R2 and R3.
- R8: Lines are independent. The steady enables of one line depend only on that line's inputs and on the mode.
- R9: On any one line, the repeater never pulls both sides low in the same cycle.
- R10: Suppose side 2 holds a line low while side 1 owns it. When side 1 releases and its copy on side 2 has drained, the held side-2 low is passed to side 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_oneway | input | 1 | 1 = clock line forwards only from side 1 to side 2 |
| s1_in | input | NLINES | Sampled side-1 line levels (0 data, 1 clock) |
| s2_in | input | NLINES | Sampled side-2 line levels |
| s1_pd_n | output | NLINES | Side-1 pull-down enables, 0 pulls low |
| s2_pd_n | output | NLINES | Side-2 pull-down enables, 0 pulls low |

## Verification
The bench closes the loop with a wired-AND bus model, so every input the design samples already includes its own pull-downs. That is exactly the situation in which a design without ownership tracking would lock a line low for good, or oscillate once its copy comes back. An exhaustive sweep covers every static pattern of side-1 and side-2 lows on both lines, in both modes. A design that gave simultaneous lows to side 1, or let side-2 clock lows through in one-way mode, would settle to the wrong enables. Directed cases measure the exact delay in each direction, reset mid-transfer, and hand-over between owners. A design that ended ownership before its far-side copy drained would either release a held low or pull both sides at once.

// File: rtl/brep_pkg.sv
package brep_pkg;
   // Which side currently owns the low on one line
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_S1   = 2'd1,
      OWN_S2   = 2'd2
   } owner_e;
endpackage

// File: rtl/brep_delay.sv
// One-way channel: a DEPTH-stage delay that resets to "released" (1).
module brep_delay #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout,
   output logic busy
);
   if (DEPTH == 1) begin : g_single
      logic q;
      always_ff @(posedge clk) begin
         if (rst) q <= 1'b1;
         else     q <= din;
      end
      assign dout = q;
      assign busy = ~q;
   end else begin : g_chain
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk) begin
         if (rst) sr <= '1;
         else     sr <= {sr[DEPTH-2:0], din};
      end
      assign dout = sr[DEPTH-1];
      // any low still travelling or at the output
      assign busy = ~&sr;
   end
endmodule

// File: rtl/brep_lane.sv
// One line: two opposite channels plus the ownership tracker.
module brep_lane
   import brep_pkg::*;
#(
   parameter int DELAY = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic oneway,
   input  logic s1_in,
   input  logic s2_in,
   output logic s1_pd_n,
   output logic s2_pd_n
);
   owner_e state, nxt;
   logic   busy12, busy21;
   logic   fwd12, fwd21;

   always_comb begin
      nxt = state;
      case (state)
         OWN_NONE: begin
            if (!oneway && !s2_in && !busy12)  nxt = OWN_S2;
            else if (!s1_in && !busy21)        nxt = OWN_S1;
         end
         OWN_S1:  if (s1_in && !busy12)             nxt = OWN_NONE;
         OWN_S2:  if (oneway || (s2_in && !busy21)) nxt = OWN_NONE;
         default: nxt = OWN_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= OWN_NONE;
      else     state <= nxt;
   end

   // only the owning side's own low enters a channel
   assign fwd12 = ~((nxt == OWN_S1) & ~s1_in);
   assign fwd21 = ~((nxt == OWN_S2) & ~s2_in);

   brep_delay #(.DEPTH(DELAY)) u_ch12 (
      .clk  (clk),
      .rst  (rst),
      .din  (fwd12),
      .dout (s2_pd_n),
      .busy (busy12)
   );

   brep_delay #(.DEPTH(DELAY)) u_ch21 (
      .clk  (clk),
      .rst  (rst),
      .din  (fwd21),
      .dout (s1_pd_n),
      .busy (busy21)
   );

   // R1
   rst_release_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (s1_pd_n && s2_pd_n && state == OWN_NONE));
   // R4
   s1_owner_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (state == OWN_S1) |-> s1_pd_n);
   // R5
   s2_owner_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (state == OWN_S2) |-> s2_pd_n);
   // R6
   s2_priority_chk: assert property (@(posedge clk) disable iff (rst)
      (state == OWN_NONE && !s1_in && !s2_in && !busy12 && !busy21 && !oneway)
      |=> (state == OWN_S2));
   // R7
   oneway_block_chk: assert property (@(posedge clk) disable iff (rst)
      (oneway && $past(oneway)) |-> (state != OWN_S2));
   // R9
   no_dual_pull_chk: assert property (@(posedge clk) disable iff (rst)
      !(!s1_pd_n && !s2_pd_n));
endmodule

// File: rtl/brep_top.sv
module brep_top #(
   parameter int NLINES      = 2,
   parameter int DELAY       = 2,
   parameter int ONEWAY_LINE = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clk_oneway,
   input  logic [NLINES-1:0] s1_in,
   input  logic [NLINES-1:0] s2_in,
   output logic [NLINES-1:0] s1_pd_n,
   output logic [NLINES-1:0] s2_pd_n
);
   if (NLINES < 1) begin : g_bad_lines
      $error("brep_top: NLINES must be at least 1");
   end
   if (DELAY < 1) begin : g_bad_delay
      $error("brep_top: DELAY must be at least 1");
   end
   if (ONEWAY_LINE < 0 || ONEWAY_LINE >= NLINES) begin : g_bad_ow
      $error("brep_top: ONEWAY_LINE out of range");
   end

   for (genvar i = 0; i < NLINES; i++) begin : g_lane
      logic ow;
      if (i == ONEWAY_LINE) begin : g_ow
         assign ow = clk_oneway;
      end else begin : g_bi
         assign ow = 1'b0;
      end

      brep_lane #(.DELAY(DELAY)) u_lane (
         .clk     (clk),
         .rst     (rst),
         .oneway  (ow),
         .s1_in   (s1_in[i]),
         .s2_in   (s2_in[i]),
         .s1_pd_n (s1_pd_n[i]),
         .s2_pd_n (s2_pd_n[i])
      );
   end
endmodule

// File: tb/tb_brep_top.sv
module tb_brep_top;
   localparam int NL = 2;
   localparam int D  = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clk_oneway = 1'b0;
   logic [NL-1:0] ext1 = '1;
   logic [NL-1:0] ext2 = '1;
   logic [NL-1:0] s1_bus, s2_bus, s1_pd_n, s2_pd_n;

   int checks = 0;
   int errors = 0;
   int dual_hits = 0;
   bit watch1 = 1'b0;
   bit watch2 = 1'b0;
   int quiet1_hits = 0;
   int quiet2_hits = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   // wired-AND bus: external drivers and the repeater's own pull-downs
   assign s1_bus = ext1 & s1_pd_n;
   assign s2_bus = ext2 & s2_pd_n;

   brep_top #(.NLINES(NL), .DELAY(D), .ONEWAY_LINE(1)) dut (
      .clk        (clk),
      .rst        (rst),
      .clk_oneway (clk_oneway),
      .s1_in      (s1_bus),
      .s2_in      (s2_bus),
      .s1_pd_n    (s1_pd_n),
      .s2_pd_n    (s2_pd_n)
   );

   // R9 monitor and echo watches (data line)
   always @(negedge clk) begin
      if (!rst) begin
         for (int i = 0; i < NL; i++)
            if (!s1_pd_n[i] && !s2_pd_n[i]) dual_hits++;
         if (watch1 && !s1_pd_n[0]) quiet1_hits++;
         if (watch2 && !s2_pd_n[0]) quiet2_hits++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_line(input int i, input bit e1, input bit e2, input string req);
      chk(s1_pd_n[i] == e1, req, int'(s1_pd_n[i]), int'(e1));
      chk(s2_pd_n[i] == e2, req, int'(s2_pd_n[i]), int'(e2));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst = 1'b0;
      cyc(1);
      // R1 reset state
      chk(s1_pd_n == '1, "R1 side1 after reset", int'(s1_pd_n), 3);
      chk(s2_pd_n == '1, "R1 side2 after reset", int'(s2_pd_n), 3);

      // R2 exact delay side1 -> side2, with R4 echo watch
      watch1 = 1'b1;
      ext1[0] = 1'b0;
      cyc(D - 1);
      chk(s2_pd_n[0] == 1'b1, "R2 before delay", int'(s2_pd_n[0]), 1);
      cyc(1);
      chk(s2_pd_n[0] == 1'b0, "R2 at delay", int'(s2_pd_n[0]), 0);
      cyc(3);
      ext1[0] = 1'b1;
      cyc(D - 1);
      chk(s2_pd_n[0] == 1'b0, "R2 release before delay", int'(s2_pd_n[0]), 0);
      cyc(1);
      chk(s2_pd_n[0] == 1'b1, "R2 release at delay", int'(s2_pd_n[0]), 1);
      cyc(2 * D + 4);
      watch1 = 1'b0;
      chk(quiet1_hits == 0, "R4 no echo on side1", quiet1_hits, 0);
      chk_line(0, 1'b1, 1'b1, "R4 back to idle");

      // R3 exact delay side2 -> side1, with R5 echo watch
      watch2 = 1'b1;
      ext2[0] = 1'b0;
      cyc(D - 1);
      chk(s1_pd_n[0] == 1'b1, "R3 before delay", int'(s1_pd_n[0]), 1);
      cyc(1);
      chk(s1_pd_n[0] == 1'b0, "R3 at delay", int'(s1_pd_n[0]), 0);
      cyc(3);
      ext2[0] = 1'b1;
      cyc(D - 1);
      chk(s1_pd_n[0] == 1'b0, "R3 release before delay", int'(s1_pd_n[0]), 0);
      cyc(1);
      chk(s1_pd_n[0] == 1'b1, "R3 release at delay", int'(s1_pd_n[0]), 1);
      cyc(2 * D + 4);
      watch2 = 1'b0;
      chk(quiet2_hits == 0, "R5 no echo on side2", quiet2_hits, 0);

      // R6 simultaneous lows, then hand-over to side 1
      ext1[0] = 1'b0;
      ext2[0] = 1'b0;
      cyc(D + 3);
      chk_line(0, 1'b0, 1'b1, "R6 side2 priority");
      ext2[0] = 1'b1;
      cyc(2 * D + 4);
      chk_line(0, 1'b1, 1'b0, "R6 held side1 low forwarded");
      ext1[0] = 1'b1;
      cyc(2 * D + 4);
      chk_line(0, 1'b1, 1'b1, "R6 idle again");

      // R10 side2 low held during side1 ownership (clock line)
      ext1[1] = 1'b0;
      cyc(D + 3);
      ext2[1] = 1'b0;
      cyc(D + 3);
      chk_line(1, 1'b1, 1'b0, "R10 side1 still owns");
      ext1[1] = 1'b1;
      cyc(2 * D + 4);
      chk_line(1, 1'b0, 1'b1, "R10 held side2 low passed");
      ext2[1] = 1'b1;
      cyc(2 * D + 4);
      chk_line(1, 1'b1, 1'b1, "R10 idle again");

      // R1 reset in the middle of a transfer
      ext1[0] = 1'b0;
      cyc(D + 3);
      rst = 1'b1;
      cyc(1);
      chk(s2_pd_n == '1, "R1 mid-run reset side2", int'(s2_pd_n), 3);
      chk(s1_pd_n == '1, "R1 mid-run reset side1", int'(s1_pd_n), 3);
      cyc(1);
      rst = 1'b0;
      cyc(D + 3);
      chk_line(0, 1'b1, 1'b0, "R2 resumes after reset");
      ext1[0] = 1'b1;
      cyc(2 * D + 4);

      // R2 R3 R6 R7 R8 exhaustive static sweep over both modes
      for (int m = 0; m < 2; m++) begin
         for (int p = 0; p < 16; p++) begin
            clk_oneway = m[0];
            cyc(1);
            ext1 = p[1:0];
            ext2 = p[3:2];
            cyc(D + 3);
            for (int i = 0; i < NL; i++) begin
               bit lo1, lo2, ow, e1, e2;
               lo1 = !p[i];
               lo2 = !p[2 + i];
               ow  = (m == 1) && (i == 1);
               if (lo2 && !ow) begin
                  e1 = 1'b0; e2 = 1'b1;
               end else if (lo1) begin
                  e1 = 1'b1; e2 = 1'b0;
               end else begin
                  e1 = 1'b1; e2 = 1'b1;
               end
               chk_line(i, e1, e2, ow ? "R7 oneway sweep" : "R8 sweep");
            end
            ext1 = '1;
            ext2 = '1;
            cyc(2 * D + 4);
            chk(s1_pd_n == '1 && s2_pd_n == '1, "R8 sweep release",
                int'({s1_pd_n, s2_pd_n}), 15);
         end
      end
      clk_oneway = 1'b0;

      chk(dual_hits == 0, "R9 never both sides pulled", dual_hits, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule